// File: doc/BRIEF.md
# Burst-Mode DMA Request Sampler

This block watches an external, active-low DMA request line and decides, state by state, whether the DMA engine should own the next bus cycle. It has two detection styles, selected by `edgeMode`. In the first, a falling edge starts a burst that runs to the end of the programmed transfer count. In the second, a low level requests transfers for as long as it stays low. Before either detector sees the pin, it passes through a synchronizer.

Bus cycles are two states long. A cycle opens with a `cycStart` state and closes with a `cycEnd` state; a sequencer outside the block produces these strobes. The sampler decides which cycles belong to the DMA. In level mode, the moment the request is re-checked depends on the address mode. In single-address mode it is checked when any bus cycle ends. In dual-address mode it is checked when a DMA read cycle starts. If a check finds the line high, sampling drops back to every state.

A down-counter holds the number of transfers left. When it reaches zero, the block sets a transfer-end flag and stops requesting cycles. Software clears the flag with `teClr` to re-arm the block.

Top module: `dma_req_sampler`

## Requirements
- R1: After reset `dmaReq` is 0, `ackN` is 1 and `teFlag` is 0.
- R2: In edge mode, the pin passes through two synchronizer flops, so `dmaReq` rises after the third rising clock edge that follows the pin's fall (high to low). Nothing is asserted after only two edges.
- R3: In edge mode, once a burst has begun `dmaReq` stays high whatever the pin does, until the final transfer completes.
- R4: `cntLoad` loads `cntVal` into the counter. A transfer completes at the `cycEnd` state of a DMA-owned cycle; in dual-address mode only a write cycle (`rdCycle`=0 at its `cycStart`) completes one. Each completed transfer decrements the counter. When it reaches zero, `teFlag` is set and `dmaReq` falls at the same edge.
- R5: While `teFlag` is 1, no DMA cycle is granted and edges on the pin are discarded. After `teClr`, edge mode needs a fresh falling edge before a burst starts.
- R6: In level mode with single-address transfers, once a low level has been seen, the pin is re-checked only in `cycEnd` states, whichever master owns that cycle. Changes between checks have no effect.
- R7: In level mode with dual-address transfers, the pin is re-checked only at the `cycStart` state of a DMA read cycle. A read already granted is always followed by its write cycle.
- R8: In level mode, a check that finds the pin high drops `dmaReq` and returns to sampling on every state. A later low level then raises `dmaReq` after three clock edges, without needing a bus cycle.
- R9: `ackN` is low for both states of a cycle whose `cycStart` saw `dmaReq` high, and high for every other state.
- R10: While the counter holds zero, `dmaReq` stays low and no cycle is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | State clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqPinN | input | 1 | Raw external request, active low |
| edgeMode | input | 1 | 1 = edge detection, 0 = low-level detection |
| dualAddr | input | 1 | 1 = dual-address transfers, 0 = single-address |
| cycStart | input | 1 | First state of a bus cycle |
| cycEnd | input | 1 | Second (last) state of a bus cycle |
| rdCycle | input | 1 | With cycStart: the cycle is a read |
| cntLoad | input | 1 | Load the transfer counter |
| cntVal | input | CNT_W | Transfer count to load |
| teClr | input | 1 | Clear the transfer-end flag |
| dmaReq | output | 1 | DMA wants the next bus cycle |
| ackN | output | 1 | Acknowledge, low during DMA-owned cycles |
| teFlag | output | 1 | Transfer-end flag |

## Verification
The embedded assertions watch, on every cycle, several properties: a running burst is never dropped before its final transfer; the level sample holds between check points; the counter steps down by exactly one per transfer and sets the flag on its last; the acknowledge covers both states of a granted cycle; and no grant happens while the flag is set or the count is zero. Other behaviours only show up over a sequence of stimulus, and the bench scenarios cover them. These include the three-edge synchronizer latency, the need for a fresh edge after re-arming, and the read-then-write pairing in dual-address mode. They also include the fall-back to every-state sampling, shown when a low level returns outside any bus cycle.

// File: rtl/dreq_pkg.sv
package dreq_pkg;
  typedef struct packed {
    logic decCnt;    // a DMA transfer completed this state
    logic endBurst;  // that transfer was the last one
  } ctlStrobeT;

  typedef enum logic {
    SAMP_EVERY = 1'b0,
    SAMP_POINT = 1'b1
  } sampModeT;
endpackage

// File: rtl/dreq_dpath.sv
module dreq_dpath
  import dreq_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqPinN,
  input  logic             cntLoad,
  input  logic [CNT_W-1:0] cntVal,
  input  logic             teClr,
  input  ctlStrobeT        strb,
  output logic             reqLow,
  output logic             reqFall,
  output logic             cntNz,
  output logic             cntOne,
  output logic             teFlag
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevQ;
  logic [CNT_W-1:0]       cntQ;
  logic                   teQ;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ <= '1;
        else       syncQ <= reqPinN;
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ <= '1;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], reqPinN};
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) prevQ <= 1'b1;
    else       prevQ <= syncQ[SYNC_STAGES-1];

  assign reqLow  = ~syncQ[SYNC_STAGES-1];
  assign reqFall = prevQ & ~syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)                      cntQ <= '0;
    else if (cntLoad)               cntQ <= cntVal;
    else if (strb.decCnt && cntNz)  cntQ <= cntQ - CNT_ONE;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)              teQ <= 1'b0;
    else if (strb.endBurst) teQ <= 1'b1;
    else if (teClr)         teQ <= 1'b0;

  assign cntNz  = (cntQ != '0);
  assign cntOne = (cntQ == CNT_ONE);
  assign teFlag = teQ;

  p_dec_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.decCnt && cntNz && !cntLoad |=> cntQ == $past(cntQ) - CNT_ONE);
  p_te_on_last_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.endBurst |=> teFlag);
  p_te_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    teClr && !strb.endBurst |=> !teFlag);
endmodule

// File: rtl/dreq_ctrl.sv
module dreq_ctrl
  import dreq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      edgeMode,
  input  logic      dualAddr,
  input  logic      cycStart,
  input  logic      cycEnd,
  input  logic      rdCycle,
  input  logic      reqLow,
  input  logic      reqFall,
  input  logic      cntNz,
  input  logic      cntOne,
  input  logic      teFlag,
  output ctlStrobeT strb,
  output logic      dmaReq,
  output logic      ackN
);
  logic     burstQ;
  logic     levelReqQ;
  sampModeT sampModeQ;
  logic     midXferQ;
  logic     inDmaQ;
  logic     rdLatQ;

  logic srcReq, grantNow, dmaOwn, xferDone, lastXfer, pointHit, sampleNow;

  assign srcReq   = edgeMode ? burstQ : levelReqQ;
  assign dmaReq   = !teFlag && cntNz && (midXferQ || srcReq);
  assign grantNow = cycStart && dmaReq;
  assign dmaOwn   = cycStart ? dmaReq : inDmaQ;
  assign ackN     = !dmaOwn;

  assign xferDone = cycEnd && inDmaQ && (!dualAddr || !rdLatQ);
  assign lastXfer = xferDone && cntOne;
  assign strb.decCnt   = xferDone;
  assign strb.endBurst = lastXfer;

  assign pointHit  = dualAddr ? (grantNow && rdCycle) : cycEnd;
  assign sampleNow = (sampModeQ == SAMP_EVERY) || pointHit;

  // edge-triggered burst: no sampling while it runs
  always_ff @(posedge clk or negedge rstN)
    if (!rstN)                     burstQ <= 1'b0;
    else if (!edgeMode || lastXfer) burstQ <= 1'b0;
    else if (!burstQ && !teFlag && cntNz && reqFall) burstQ <= 1'b1;

  // level-triggered sampling point selection
  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      levelReqQ <= 1'b0;
      sampModeQ <= SAMP_EVERY;
    end else if (edgeMode || lastXfer) begin
      levelReqQ <= 1'b0;
      sampModeQ <= SAMP_EVERY;
    end else if (sampleNow) begin
      levelReqQ <= reqLow;
      sampModeQ <= reqLow ? SAMP_POINT : SAMP_EVERY;
    end

  // bus-cycle ownership and read/write pairing
  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      inDmaQ <= 1'b0;
      rdLatQ <= 1'b0;
    end else if (cycStart) begin
      inDmaQ <= dmaReq;
      rdLatQ <= rdCycle;
    end else if (cycEnd) begin
      inDmaQ <= 1'b0;
    end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)        midXferQ <= 1'b0;
    else if (xferDone) midXferQ <= 1'b0;
    else if (dualAddr && grantNow && rdCycle) midXferQ <= 1'b1;

  p_burst_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    edgeMode && burstQ && !lastXfer |=> burstQ);
  p_point_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !edgeMode && sampModeQ == SAMP_POINT && !sampleNow && !lastXfer
      |=> levelReqQ == $past(levelReqQ));
  p_ack_both_states_r9: assert property (@(posedge clk) disable iff (!rstN)
    cycStart && !ackN |=> (!cycEnd || !ackN));
  p_te_no_grant_r5: assert property (@(posedge clk) disable iff (!rstN)
    teFlag && cycStart |-> ackN);
  p_zero_no_grant_r10: assert property (@(posedge clk) disable iff (!rstN)
    !cntNz && cycStart |-> ackN);
endmodule

// File: rtl/dma_req_sampler.sv
module dma_req_sampler
  import dreq_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqPinN,
  input  logic             edgeMode,
  input  logic             dualAddr,
  input  logic             cycStart,
  input  logic             cycEnd,
  input  logic             rdCycle,
  input  logic             cntLoad,
  input  logic [CNT_W-1:0] cntVal,
  input  logic             teClr,
  output logic             dmaReq,
  output logic             ackN,
  output logic             teFlag
);
  ctlStrobeT strb;
  logic reqLow, reqFall, cntNz, cntOne;

  dreq_dpath #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_dpath (
    .clk(clk), .rstN(rstN), .reqPinN(reqPinN), .cntLoad(cntLoad),
    .cntVal(cntVal), .teClr(teClr), .strb(strb), .reqLow(reqLow),
    .reqFall(reqFall), .cntNz(cntNz), .cntOne(cntOne), .teFlag(teFlag)
  );

  dreq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .edgeMode(edgeMode), .dualAddr(dualAddr),
    .cycStart(cycStart), .cycEnd(cycEnd), .rdCycle(rdCycle),
    .reqLow(reqLow), .reqFall(reqFall), .cntNz(cntNz), .cntOne(cntOne),
    .teFlag(teFlag), .strb(strb), .dmaReq(dmaReq), .ackN(ackN)
  );
endmodule

// File: tb/dma_req_sampler_test.sv
module dma_req_sampler_test;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqPinN = 1'b1, edgeMode = 1'b0, dualAddr = 1'b0;
  logic cycStart = 1'b0, cycEnd = 1'b0, rdCycle = 1'b0;
  logic cntLoad = 1'b0, teClr = 1'b0;
  logic [CW-1:0] cntVal = '0;
  logic dmaReq, ackN, teFlag;

  int total = 0, bad = 0;
  int ackCnt;
  bit wrNext, modelOn = 0, finished = 0;

  always #2 clk = ~clk;

  dma_req_sampler #(.CNT_W(CW)) uut (
    .clk(clk), .rstN(rstN), .reqPinN(reqPinN), .edgeMode(edgeMode),
    .dualAddr(dualAddr), .cycStart(cycStart), .cycEnd(cycEnd),
    .rdCycle(rdCycle), .cntLoad(cntLoad), .cntVal(cntVal), .teClr(teClr),
    .dmaReq(dmaReq), .ackN(ackN), .teFlag(teFlag)
  );

  // behavioural expectation of the requirements
  logic mS1, mS2, mPrev, mTe, mBurst, mLvl, mPt, mMid, mIn, mRd;
  logic [CW-1:0] mCnt;

  function automatic logic expReq();
    logic src;
    src = edgeMode ? mBurst : mLvl;
    return !mTe && (mCnt != 0) && (mMid || src);
  endfunction

  function automatic logic expAckN();
    return cycStart ? !expReq() : !mIn;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mS1 = 1; mS2 = 1; mPrev = 1; mTe = 0; mBurst = 0; mLvl = 0;
      mPt = 0; mMid = 0; mIn = 0; mRd = 0; mCnt = '0;
    end else begin
      logic req, done, last, fall, low, hit;
      req  = expReq();
      done = cycEnd && mIn && (!dualAddr || !mRd);
      last = done && (mCnt == 1);
      fall = mPrev && !mS2;
      low  = !mS2;
      hit  = dualAddr ? (cycStart && req && rdCycle) : cycEnd;
      if (!edgeMode || last) mBurst = 0;
      else if (!mBurst && !mTe && mCnt != 0 && fall) mBurst = 1;
      if (edgeMode || last) begin mLvl = 0; mPt = 0; end
      else if (!mPt || hit) begin mLvl = low; mPt = low; end
      if (done) mMid = 0;
      else if (dualAddr && cycStart && req && rdCycle) mMid = 1;
      if (cycStart) begin mIn = req; mRd = rdCycle; end
      else if (cycEnd) mIn = 0;
      if (last) mTe = 1; else if (teClr) mTe = 0;
      if (cntLoad) mCnt = cntVal; else if (done && mCnt != 0) mCnt = mCnt - 1;
      mPrev = mS2; mS2 = mS1; mS1 = reqPinN;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (rstN && modelOn) begin
      chk(edgeMode ? "R3 dmaReq track" : (dualAddr ? "R7 dmaReq track" : "R6 dmaReq track"),
          32'(dmaReq), 32'(expReq()));
      chk("R9 ackN track", 32'(ackN), 32'(expAckN()));
      chk("R4 teFlag track", 32'(teFlag), 32'(mTe));
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busCycle();
    @(negedge clk);
    cycStart = 1;
    if (dualAddr && dmaReq) begin rdCycle = !wrNext; wrNext = !wrNext; end
    else rdCycle = 0;
    #1 if (!ackN) ackCnt++;
    @(negedge clk);
    cycStart = 0; rdCycle = 0; cycEnd = 1;
    @(negedge clk);
    cycEnd = 0;
  endtask

  task automatic doReset(bit em, bit da);
    @(negedge clk);
    rstN = 0; edgeMode = em; dualAddr = da; reqPinN = 1;
    wrNext = 0;
    idle(3);
    rstN = 1;
  endtask

  task automatic load(int v);
    @(negedge clk); cntLoad = 1; cntVal = CW'(v);
    @(negedge clk); cntLoad = 0;
  endtask

  task automatic clearTe();
    @(negedge clk); teClr = 1;
    @(negedge clk); teClr = 0;
  endtask

  initial begin
    int unused;
    unused = $urandom(32'h5eed_1234);
    doReset(1, 0);
    #1;
    chk("R1 dmaReq reset", 32'(dmaReq), 0);
    chk("R1 ackN reset", 32'(ackN), 1);
    chk("R1 teFlag reset", 32'(teFlag), 0);
    modelOn = 1;

    // R2 latency, R3 burst holds, R4 count end
    load(4);
    @(negedge clk); reqPinN = 0;
    @(posedge clk); @(posedge clk); #1;
    chk("R2 no request after two edges", 32'(dmaReq), 0);
    @(posedge clk); #1;
    chk("R2 request after third edge", 32'(dmaReq), 1);
    ackCnt = 0;
    for (int i = 0; i < 8; i++) begin
      reqPinN = i[0];
      busCycle();
    end
    chk("R3 burst ran to count", 32'(ackCnt), 4);
    chk("R4 teFlag at zero", 32'(teFlag), 1);
    chk("R4 dmaReq low at end", 32'(dmaReq), 0);

    // R5 flag blocks, fresh edge needed
    @(negedge clk); reqPinN = 1; idle(3); reqPinN = 0; idle(3);
    ackCnt = 0;
    repeat (4) busCycle();
    chk("R5 no grant while flag set", 32'(ackCnt), 0);
    load(3); clearTe(); idle(2);
    chk("R5 flag cleared", 32'(teFlag), 0);
    ackCnt = 0;
    repeat (4) busCycle();
    chk("R5 stale edge ignored", 32'(ackCnt), 0);
    @(negedge clk); reqPinN = 1; idle(3); reqPinN = 0; idle(3);
    ackCnt = 0;
    repeat (5) busCycle();
    chk("R5 fresh edge rearms", 32'(ackCnt), 3);

    // R10 zero count
    doReset(0, 0);
    @(negedge clk); reqPinN = 0; idle(5);
    chk("R10 no request with zero count", 32'(dmaReq), 0);
    ackCnt = 0;
    repeat (2) busCycle();
    chk("R10 no grant with zero count", 32'(ackCnt), 0);
    chk("R9 ackN high on CPU cycles", 32'(ackN), 1);

    // R6 / R8 level single
    load(20); idle(4);
    chk("R6 low level seen", 32'(dmaReq), 1);
    @(negedge clk); reqPinN = 1; idle(6);
    chk("R6 no sample between cycle ends", 32'(dmaReq), 1);
    ackCnt = 0;
    busCycle();
    chk("R9 granted cycle acknowledged", 32'(ackCnt), 1);
    chk("R8 high at cycle end drops request", 32'(dmaReq), 0);
    reqPinN = 0;
    @(posedge clk); @(posedge clk); @(posedge clk); #1;
    chk("R8 every-state sampling resumes", 32'(dmaReq), 1);

    // R7 level dual
    doReset(0, 1);
    load(10);
    @(negedge clk); reqPinN = 0; idle(4);
    chk("R7 low level seen", 32'(dmaReq), 1);
    @(negedge clk); reqPinN = 1; idle(6);
    chk("R7 no sample outside read start", 32'(dmaReq), 1);
    ackCnt = 0;
    repeat (3) busCycle();
    chk("R7 read paired with write", 32'(ackCnt), 2);
    chk("R7 request dropped after pair", 32'(dmaReq), 0);

    // constrained random over all four modes
    for (int m = 0; m < 4; m++) begin
      doReset(m[0], m[1]);
      load(1 + ($urandom % 6));
      for (int s = 0; s < 400; s++) begin
        int act;
        act = $urandom % 8;
        if (act < 2) begin @(negedge clk); reqPinN = $urandom % 2; end
        else if (act == 2) idle(1 + $urandom % 3);
        else if (act == 7 && teFlag) begin load(1 + ($urandom % 6)); clearTe(); end
        else busCycle();
      end
    end

    idle(2);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule